// File: doc/BRIEF.md
# GPIO controller with interrupt sensing

This block drives and samples 64 general-purpose pins. The pins are arranged as two banks of 32. Each pin has four things: a direction bit, a bit that hands the pin to an alternate function, an output latch, and a readback of its input through a synchronizer. Software reaches all of this state through a simple synchronous register port. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`.

The lowest 16 pins can also raise interrupts. Each of these pins has three trigger bits: edge, high and low. The high and low bits choose the polarity. The edge bit chooses between live level reporting and sticky edge capture. A pin also has an enable bit and a clear bit. A latched request stays cleared for as long as its clear bit is 1, so software writes the bit to 1 and then back to 0 to re-arm the pin. All enabled requests are combined into one interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is all 0, `pin_out` is all 0 while no alternate function is selected, and `irq` is 0.
- R2: Word addresses: 0x0/0x1 direction, 0x2/0x3 function select, 0x4/0x5 output latch, 0x6/0x7 input (read only), 0x8 edge, 0x9 high, 0xA low, 0xB enable, 0xC clear, 0xD status (read only). In each pair, the even address holds pins 0–31 at bit n and the odd address holds pins 32–63 at bit n−32. Other addresses read 0.
- R3: When a pin's select bit is 0, `pin_oe` equals its direction bit (1 = output) and `pin_out` equals its output latch bit.
- R4: When a pin's select bit is 1, `pin_oe` follows `alt_oe` and `pin_out` follows `alt_out`.
- R5: A change on `pin_in` appears in the input registers after the second rising clock edge, and not before.
- R6: With edge=0, high alone reports the status bit live while the synchronized pin is 1, and low alone reports it live while the pin is 0. No latch is involved.
- R7: With edge=1, high alone captures rising edges and low alone captures falling edges. High and low together capture either edge. A captured status bit stays 1 until it is cleared.
- R8: A pin whose edge, high and low bits are all 0 never shows status and never raises `irq`.
- R9: While a clear bit is 1, the matching status bit reads 0 and edges are not captured. Once the bit is written back to 0, new edges are captured again.
- R10: `irq` is the OR over pins 0–15 of status AND enable. Status can be read even when the pin's enable bit is 0.
- R11: The edge, high, low, enable, clear and status registers are 16 bits wide. Their bits 31:16 read 0, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| pin_in | input | 64 | Asynchronous pin inputs |
| pin_out | output | 64 | Pin output values |
| pin_oe | output | 64 | Pin output enables |
| alt_out | input | 64 | Alternate-function output values |
| alt_oe | input | 64 | Alternate-function output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge that arrives while the pin's clear bit is held at 1. The edge must be dropped. The pin must then capture the next qualifying edge once the clear bit returns to 0. To reach this, the stimulus writes the clear bit to 1 and moves the pin across the full two-flop synchronizer delay. It checks that status stays 0, releases the clear bit, confirms that no stale request appears, and then sends an edge of the opposite polarity followed by one of the selected polarity. Every interrupt test picks its pin at random from 0–15. Each status sample waits three edges after the pin changes: two for the synchronizer and one for the sticky capture.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int ADRW = 4;

  // Banked registers: base address plus bank index
  localparam logic [ADRW-1:0] ADR_DIR  = 4'h0;
  localparam logic [ADRW-1:0] ADR_SEL  = 4'h2;
  localparam logic [ADRW-1:0] ADR_OUT  = 4'h4;
  localparam logic [ADRW-1:0] ADR_IN   = 4'h6;
  // Interrupt registers, one each
  localparam logic [ADRW-1:0] ADR_EDGE = 4'h8;
  localparam logic [ADRW-1:0] ADR_HIGH = 4'h9;
  localparam logic [ADRW-1:0] ADR_LOW  = 4'hA;
  localparam logic [ADRW-1:0] ADR_EN   = 4'hB;
  localparam logic [ADRW-1:0] ADR_CLR  = 4'hC;
  localparam logic [ADRW-1:0] ADR_STAT = 4'hD;

  function automatic logic [ADRW-1:0] bank_adr(input logic [ADRW-1:0] base, input int bank);
    return base + ADRW'(bank);
  endfunction

  // Edge qualifier: polarity bits select which transitions count
  function automatic logic edge_match(input logic hi, input logic lo,
                                      input logic cur, input logic prev);
    return (hi & cur & ~prev) | (lo & ~cur & prev);
  endfunction

  // Level qualifier: polarity bits select which level counts
  function automatic logic level_match(input logic hi, input logic lo, input logic cur);
    return (hi & cur) | (lo & ~cur);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

  // R5
  sync_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o == $past(stage1_q));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] latch_i,
  input  logic [W-1:0] alt_out_i,
  input  logic [W-1:0] alt_oe_i,
  output logic [W-1:0] pin_out_o,
  output logic [W-1:0] pin_oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pin_oe_o[i]  = sel_i[i] ? alt_oe_i[i]  : dir_i[i];
    assign pin_out_o[i] = sel_i[i] ? alt_out_i[i] : latch_i[i];
  end

  // R3
  gpio_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe_o ^ dir_i) & ~sel_i) == '0);
  // R4
  alt_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe_o ^ alt_oe_i) & sel_i) == '0);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit import gpio_ctrl_pkg::*; #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] smp_i,
  input  logic [N-1:0] trig_edge_i,
  input  logic [N-1:0] trig_high_i,
  input  logic [N-1:0] trig_low_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] prev_q, sticky_q, sticky_d;
  logic [N-1:0] edge_hit, level_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      sticky_q <= '0;
    end else begin
      prev_q   <= smp_i;
      sticky_q <= sticky_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign edge_hit[i]  = trig_edge_i[i] &
                          edge_match(trig_high_i[i], trig_low_i[i], smp_i[i], prev_q[i]);
    assign level_hit[i] = ~trig_edge_i[i] &
                          level_match(trig_high_i[i], trig_low_i[i], smp_i[i]);
    assign sticky_d[i]  = (clr_i[i] | ~trig_edge_i[i]) ? 1'b0 : (sticky_q[i] | edge_hit[i]);
    assign status_o[i]  = ~clr_i[i] & (trig_edge_i[i] ? sticky_q[i] : level_hit[i]);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[i] && trig_edge_i[i] && !clr_i[i]) |=> sticky_q[i]);
    // R7
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit[i] && !clr_i[i]) |=> sticky_q[i]);
    // R9
    clr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[i] |=> !sticky_q[i]);
    // R8
    quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig_edge_i[i] || trig_high_i[i] || trig_low_i[i]) |-> !status_o[i]);
  end

  assign irq_o = |(status_o & en_i);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_i != '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl import gpio_ctrl_pkg::*; #(
  parameter int NPINS = 64,
  parameter int BANKW = 32,
  parameter int NIRQ  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADRW-1:0]  addr,
  input  logic [BANKW-1:0] wdata,
  output logic [BANKW-1:0] rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic [NPINS-1:0] alt_out,
  input  logic [NPINS-1:0] alt_oe,
  output logic             irq
);
  localparam int BANKS = NPINS / BANKW;

  logic [NPINS-1:0] dir_q, sel_q, out_q, smp;
  logic [NIRQ-1:0]  edge_q, high_q, low_q, en_q, clr_q, status;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(smp)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_q[b*BANKW +: BANKW] <= '0;
        sel_q[b*BANKW +: BANKW] <= '0;
        out_q[b*BANKW +: BANKW] <= '0;
      end else if (wr_en) begin
        if (addr == bank_adr(ADR_DIR, b)) dir_q[b*BANKW +: BANKW] <= wdata;
        if (addr == bank_adr(ADR_SEL, b)) sel_q[b*BANKW +: BANKW] <= wdata;
        if (addr == bank_adr(ADR_OUT, b)) out_q[b*BANKW +: BANKW] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      high_q <= '0;
      low_q  <= '0;
      en_q   <= '0;
      clr_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        ADR_EDGE: edge_q <= wdata[NIRQ-1:0];
        ADR_HIGH: high_q <= wdata[NIRQ-1:0];
        ADR_LOW:  low_q  <= wdata[NIRQ-1:0];
        ADR_EN:   en_q   <= wdata[NIRQ-1:0];
        ADR_CLR:  clr_q  <= wdata[NIRQ-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (addr == bank_adr(ADR_DIR, b)) rdata = dir_q[b*BANKW +: BANKW];
      if (addr == bank_adr(ADR_SEL, b)) rdata = sel_q[b*BANKW +: BANKW];
      if (addr == bank_adr(ADR_OUT, b)) rdata = out_q[b*BANKW +: BANKW];
      if (addr == bank_adr(ADR_IN, b))  rdata = smp[b*BANKW +: BANKW];
    end
    case (addr)
      ADR_EDGE: rdata = BANKW'(edge_q);
      ADR_HIGH: rdata = BANKW'(high_q);
      ADR_LOW:  rdata = BANKW'(low_q);
      ADR_EN:   rdata = BANKW'(en_q);
      ADR_CLR:  rdata = BANKW'(clr_q);
      ADR_STAT: rdata = BANKW'(status);
      default: ;
    endcase
  end

  gpio_pad_mux #(.W(NPINS)) u_pad (
    .clk(clk), .rst_n(rst_n),
    .dir_i(dir_q), .sel_i(sel_q), .latch_i(out_q),
    .alt_out_i(alt_out), .alt_oe_i(alt_oe),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  gpio_irq_unit #(.N(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .smp_i(smp[NIRQ-1:0]),
    .trig_edge_i(edge_q), .trig_high_i(high_q), .trig_low_i(low_q),
    .clr_i(clr_q), .en_i(en_q),
    .status_o(status), .irq_o(irq)
  );

  // R11
  irq_reg_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= ADR_EDGE && addr <= ADR_STAT) |-> (rdata[BANKW-1:NIRQ] == '0));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] pins = '0;
  logic [63:0] pin_out, pin_oe;
  logic [63:0] alt_out = '0, alt_oe = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  function automatic logic [63:0] exp_oe(input logic [63:0] dir, input logic [63:0] sel,
                                         input logic [63:0] aoe);
    return (dir & ~sel) | (aoe & sel);
  endfunction

  function automatic logic [63:0] exp_out(input logic [63:0] lat, input logic [63:0] sel,
                                          input logic [63:0] ao);
    return (lat & ~sel) | (ao & sel);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, 64'(rdata), 64'(exp));
  endtask

  task automatic set_pin(input int p, input logic v);
    pins[p] = v;
    tick(3);
  endtask

  task automatic clear_all();
    wr(4'hC, 32'hFFFF);
    wr(4'hC, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] dir, sel, lat;
    logic [31:0] bit_m;
    int p;
    void'($urandom(32'h5eed_1234));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    for (int a = 0; a < 16; a++) rd("R1 reset read", 4'(a), 32'h0);
    chk("R1 reset oe", pin_oe, 64'h0);
    chk("R1 reset out", pin_out, 64'h0);
    chk("R1 reset irq", 64'(irq), 64'h0);

    // R2 R3 R4 random pad configurations
    for (int it = 0; it < 30; it++) begin
      dir = {$urandom, $urandom};
      sel = (it < 5) ? 64'h0 : {$urandom, $urandom};
      lat = {$urandom, $urandom};
      alt_out = {$urandom, $urandom};
      alt_oe = {$urandom, $urandom};
      wr(4'h0, dir[31:0]); wr(4'h1, dir[63:32]);
      wr(4'h2, sel[31:0]); wr(4'h3, sel[63:32]);
      wr(4'h4, lat[31:0]); wr(4'h5, lat[63:32]);
      rd("R2 dir lo", 4'h0, dir[31:0]);
      rd("R2 dir hi", 4'h1, dir[63:32]);
      rd("R2 sel hi", 4'h3, sel[63:32]);
      rd("R2 out lo", 4'h4, lat[31:0]);
      chk("R3 R4 pin_oe", pin_oe, exp_oe(dir, sel, alt_oe));
      chk("R3 R4 pin_out", pin_out, exp_out(lat, sel, alt_out));
    end
    rd("R2 unmapped", 4'hF, 32'h0);
    wr(4'h6, 32'hFFFF_FFFF);
    rd("R2 input read-only", 4'h6, 32'h0);

    // R5 synchronizer latency on a high-bank pin
    pins = 64'h8000_0001_0000_0000;
    tick(1);
    rd("R5 not yet visible", 4'h7, 32'h0);
    tick(1);
    rd("R5 visible hi bank", 4'h7, 32'h8000_0001);
    pins = '0;
    tick(3);

    // Interrupt tests on a random low pin
    p = $urandom_range(15);
    bit_m = 32'h1 << p;

    // R6 level high
    wr(4'h9, bit_m);
    rd("R6 level high idle", 4'hD, 32'h0);
    set_pin(p, 1'b1);
    rd("R6 level high active", 4'hD, bit_m);
    set_pin(p, 1'b0);
    rd("R6 level high released", 4'hD, 32'h0);
    // R6 level low
    wr(4'h9, 32'h0); wr(4'hA, bit_m);
    rd("R6 level low active", 4'hD, bit_m);
    wr(4'hB, bit_m);
    chk("R10 irq level", 64'(irq), 64'h1);
    set_pin(p, 1'b1);
    rd("R6 level low released", 4'hD, 32'h0);
    chk("R10 irq drops", 64'(irq), 64'h0);
    wr(4'hB, 32'h0);

    // R7 rising only
    wr(4'hA, 32'h0); wr(4'h9, bit_m); wr(4'h8, bit_m);
    set_pin(p, 1'b0);
    rd("R7 falling ignored", 4'hD, 32'h0);
    set_pin(p, 1'b1);
    rd("R7 rising captured", 4'hD, bit_m);
    set_pin(p, 1'b0);
    rd("R7 sticky", 4'hD, bit_m);
    chk("R10 irq masked", 64'(irq), 64'h0);
    wr(4'hB, bit_m);
    chk("R10 irq enabled", 64'(irq), 64'h1);

    // R9 clear held
    wr(4'hC, bit_m);
    rd("R9 held clear", 4'hD, 32'h0);
    chk("R9 irq cleared", 64'(irq), 64'h0);
    set_pin(p, 1'b1);
    rd("R9 edge dropped", 4'hD, 32'h0);
    wr(4'hC, 32'h0);
    tick(1);
    rd("R9 no stale", 4'hD, 32'h0);
    set_pin(p, 1'b0);
    rd("R9 fall ignored", 4'hD, 32'h0);
    set_pin(p, 1'b1);
    rd("R9 rearmed", 4'hD, bit_m);
    chk("R10 irq rearmed", 64'(irq), 64'h1);

    // R7 falling only
    clear_all();
    wr(4'h9, 32'h0); wr(4'hA, bit_m);
    set_pin(p, 1'b0);
    rd("R7 falling captured", 4'hD, bit_m);
    // R7 both edges
    clear_all();
    wr(4'h9, bit_m);
    set_pin(p, 1'b1);
    rd("R7 any edge rise", 4'hD, bit_m);
    clear_all();
    set_pin(p, 1'b0);
    rd("R7 any edge fall", 4'hD, bit_m);

    // R8 no mode
    wr(4'h8, 32'h0); wr(4'h9, 32'h0); wr(4'hA, 32'h0);
    set_pin(p, 1'b1);
    set_pin(p, 1'b0);
    rd("R8 quiet", 4'hD, 32'h0);
    chk("R8 irq quiet", 64'(irq), 64'h0);

    // R11 register width
    wr(4'h8, 32'hFFFF_FFFF);
    rd("R11 edge width", 4'h8, 32'h0000_FFFF);
    wr(4'hB, 32'hA5A5_0000);
    rd("R11 enable width", 4'hB, 32'h0);
    wr(4'h9, 32'hFFFF_FFFF);
    pins[40] = 1'b1;
    tick(3);
    rd("R11 high pins silent", 4'hD, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule